// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer with Selective Flush

This block is a small fully associative translation cache. Every line stores a 20-bit virtual page number (4 KiB pages within a 32-bit virtual address), a 7-bit address-space identifier, a 20-bit physical frame number and 3 permission bits. A lookup port presents a page number and an identifier, and the registered answer (hit, frame, permissions) appears one cycle later. A page-table walker, which lies outside this block, writes new translations through a fill port.

Invalidation is requested with one 32-bit command word. Its low two bits choose how virtual addresses are matched: every address, one 4 MiB section or one 16 KiB group. Its top bit adds a condition on the identifier. A line is dropped only when every enabled condition holds for it. Two configuration inputs complete the block. A global translation enable turns lookups and fills on or off. A 6-bit active-line count limits the set of lines that take part in hits, fills and replacement.

Top module: `tlb_asid_cache`

## Requirements
- R1: A lookup accepted on a clock edge produces `respValid` high after that edge. `respHit` is 1, with the stored frame and permissions, only when an active valid line matches both the page number and the identifier. A mismatch in either gives a miss.
- R2: A fill writes the lowest-numbered active line that is not valid. Lines that already hold translations are left alone.
- R3: When every active line is valid, a fill replaces the line named by a round-robin victim pointer. The pointer then advances and wraps to line 0 after the last active line.
- R4: The number of active lines is `activeLines`. A value of 0 counts as 1 and a value above the line count counts as all lines. A line at or above this number never hits and is never filled, but its contents are kept and it hits again once the count grows back over it.
- R5: A flush command with bits 1:0 = 0 and bit 31 = 0 invalidates every line.
- R6: When command bit 31 is 1, only lines whose identifier equals command bits 30:24 are eligible for invalidation.
- R7: Mode 2 (section) invalidates lines whose page-number bits 19:10 (virtual address bits 31:22) equal command bits 19:10.
- R8: Mode 3 (group) invalidates lines whose page-number bits 19:2 (virtual address bits 31:14) equal command bits 19:2.
- R9: When the identifier condition and a range mode are both given, a line is invalidated only if it meets both.
- R10: Mode 1 is reserved. A command with bits 1:0 = 1 invalidates nothing.
- R11: A lookup in the same cycle as a flush is answered from the state after that flush.
- R12: While `translateEn` is 0, every lookup answers a miss and fills are discarded. Lines stored earlier hit again once it returns to 1.
- R13: A fill that arrives in the same cycle as a flush is kept, even if the flush would match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| translateEn | input | 1 | Global translation enable |
| activeLines | input | 6 | Number of lines in use |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | 20 | Page number to translate |
| lookupAsid | input | 7 | Identifier of the lookup |
| respValid | output | 1 | Lookup answer valid |
| respHit | output | 1 | Lookup hit |
| respPfn | output | 20 | Frame number on a hit |
| respPerm | output | 3 | Permission bits on a hit |
| fillValid | input | 1 | Fill request from the walker |
| fillVpn | input | 20 | Page number of the fill |
| fillAsid | input | 7 | Identifier of the fill |
| fillPfn | input | 20 | Frame number of the fill |
| fillPerm | input | 3 | Permission bits of the fill |
| flushValid | input | 1 | Flush command strobe |
| flushCmd | input | 32 | Flush command word |

## Verification
The embedded properties assume that the walker never fills a page number and identifier pair that is already present. Under that assumption at most one line can match a lookup, and the properties rely on this. The stimulus keeps to it: every fill either uses a pair that has never been written, or follows a flush or eviction that has already removed that pair. The properties on full and reserved flushes only apply in cycles without a fill. Stimulus that combines a flush with a fill is checked by the scoreboard alone.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
  localparam int VPN_W      = 20;
  localparam int PFN_W      = 20;
  localparam int ASID_W     = 7;
  localparam int PERM_W     = 3;
  localparam int LINE_IDX_W = 6;   // up to 64 lines
  localparam int CMD_W      = 32;
  localparam int GROUP_KEY_W = VPN_W - 2;  // page number bits 19:2
  localparam int SECT_KEY_LSB = 8;         // key bit for page number bit 10

  // command word field positions
  localparam int CMD_ASID_EN  = 31;
  localparam int CMD_ASID_LSB = 24;
  localparam int CMD_KEY_LSB  = 2;
  localparam int CMD_KEY_MSB  = 19;

  typedef enum logic [1:0] {
    VA_ALL     = 2'd0,
    VA_RSVD    = 2'd1,
    VA_SECTION = 2'd2,
    VA_GROUP   = 2'd3
  } vaMatchE;

  typedef struct packed {
    logic                   lookupEn;
    logic                   fillWe;
    logic [LINE_IDX_W-1:0]  fillLine;
    logic                   flushEn;
    vaMatchE                flushMode;
    logic                   asidMatchEn;
    logic [ASID_W-1:0]      flushAsid;
    logic [GROUP_KEY_W-1:0] flushKey;
  } tlbStrobeT;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_asid_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 translateEn,
  input  logic [5:0]           activeLines,
  input  logic                 fillValid,
  input  logic                 flushValid,
  input  logic [CMD_W-1:0]     flushCmd,
  input  logic [NUM_LINES-1:0] validVec,
  output logic [NUM_LINES-1:0] lineActive,
  output tlbStrobeT            strobes
);
  localparam int CNT_W = LINE_IDX_W + 1;

  logic [CNT_W-1:0]      effLines;
  logic                  freeFound;
  logic [LINE_IDX_W-1:0] freeIdx;
  logic [LINE_IDX_W-1:0] victimPtr;
  logic [LINE_IDX_W-1:0] victimUse;
  logic [LINE_IDX_W-1:0] victimNext;
  logic                  fillWe;
  logic                  unusedCmdBits;

  assign unusedCmdBits = ^flushCmd[CMD_ASID_LSB-1:CMD_KEY_MSB+1];

  always_comb begin
    if (activeLines == '0)
      effLines = CNT_W'(1);
    else if (int'(activeLines) > NUM_LINES)
      effLines = CNT_W'(NUM_LINES);
    else
      effLines = CNT_W'(activeLines);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_active
    assign lineActive[i] = (CNT_W'(i) < effLines);
  end

  // lowest-numbered free active line
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (!validVec[i] && lineActive[i]) begin
        freeFound = 1'b1;
        freeIdx   = LINE_IDX_W'(i);
      end
    end
  end

  always_comb begin
    victimUse  = (CNT_W'(victimPtr) >= effLines) ? '0 : victimPtr;
    victimNext = ((CNT_W'(victimUse) + CNT_W'(1)) >= effLines) ? '0
                                                               : victimUse + 1'b1;
  end

  assign fillWe = fillValid && translateEn;

  always_ff @(posedge clk) begin
    if (!rstN)
      victimPtr <= '0;
    else if (fillWe && !freeFound)
      victimPtr <= victimNext;
  end

  always_comb begin
    strobes.lookupEn    = translateEn;
    strobes.fillWe      = fillWe;
    strobes.fillLine    = freeFound ? freeIdx : victimUse;
    strobes.flushEn     = flushValid;
    strobes.flushMode   = vaMatchE'(flushCmd[1:0]);
    strobes.asidMatchEn = flushCmd[CMD_ASID_EN];
    strobes.flushAsid   = flushCmd[CMD_ASID_LSB +: ASID_W];
    strobes.flushKey    = flushCmd[CMD_KEY_MSB:CMD_KEY_LSB];
  end

  // R4: a fill always lands on an active line
  a_r4_fill_in_active: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillWe |-> (CNT_W'(strobes.fillLine) < effLines));

  // R3: the victim pointer stays inside the array
  a_r3_victim_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(victimPtr) < NUM_LINES);

  // R2: a free active line is preferred to replacement
  a_r2_free_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fillWe && freeFound) |-> !validVec[strobes.fillLine]);
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_asid_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tlbStrobeT            strobes,
  input  logic [NUM_LINES-1:0] lineActive,
  input  logic                 lookupValid,
  input  logic [VPN_W-1:0]     lookupVpn,
  input  logic [ASID_W-1:0]    lookupAsid,
  input  logic [VPN_W-1:0]     fillVpn,
  input  logic [ASID_W-1:0]    fillAsid,
  input  logic [PFN_W-1:0]     fillPfn,
  input  logic [PERM_W-1:0]    fillPerm,
  output logic [NUM_LINES-1:0] validVec,
  output logic                 respValid,
  output logic                 respHit,
  output logic [PFN_W-1:0]     respPfn,
  output logic [PERM_W-1:0]    respPerm
);
  logic [NUM_LINES-1:0] validQ;
  logic [VPN_W-1:0]     vpnQ  [NUM_LINES];
  logic [ASID_W-1:0]    asidQ [NUM_LINES];
  logic [PFN_W-1:0]     pfnQ  [NUM_LINES];
  logic [PERM_W-1:0]    permQ [NUM_LINES];

  logic [NUM_LINES-1:0] killVec;
  logic [NUM_LINES-1:0] hitVec;
  logic [PFN_W-1:0]     hitPfn;
  logic [PERM_W-1:0]    hitPerm;

  assign validVec = validQ;

  always_comb begin
    logic asidOk;
    logic vaOk;
    for (int i = 0; i < NUM_LINES; i++) begin
      asidOk = !strobes.asidMatchEn || (asidQ[i] == strobes.flushAsid);
      case (strobes.flushMode)
        VA_ALL:     vaOk = 1'b1;
        VA_SECTION: vaOk = (vpnQ[i][VPN_W-1:10] ==
                            strobes.flushKey[GROUP_KEY_W-1:SECT_KEY_LSB]);
        VA_GROUP:   vaOk = (vpnQ[i][VPN_W-1:2] == strobes.flushKey);
        default:    vaOk = 1'b0;
      endcase
      killVec[i] = strobes.flushEn && validQ[i] && asidOk && vaOk;
      hitVec[i]  = strobes.lookupEn && lineActive[i] && validQ[i] && !killVec[i] &&
                   (vpnQ[i] == lookupVpn) && (asidQ[i] == lookupAsid);
    end
  end

  always_comb begin
    hitPfn  = '0;
    hitPerm = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      hitPfn  = hitPfn  | ({PFN_W{hitVec[i]}}  & pfnQ[i]);
      hitPerm = hitPerm | ({PERM_W{hitVec[i]}} & permQ[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        vpnQ[i]  <= '0;
        asidQ[i] <= '0;
        pfnQ[i]  <= '0;
        permQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strobes.fillWe && (strobes.fillLine == LINE_IDX_W'(i))) begin
          validQ[i] <= 1'b1;
          vpnQ[i]   <= fillVpn;
          asidQ[i]  <= fillAsid;
          pfnQ[i]   <= fillPfn;
          permQ[i]  <= fillPerm;
        end else if (killVec[i]) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPfn   <= '0;
      respPerm  <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && (|hitVec);
      respPfn   <= hitPfn;
      respPerm  <= hitPerm;
    end
  end

  // R1: relies on the walker never duplicating a page/identifier pair
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R1: every accepted lookup is answered on the next cycle
  a_r1_resp_next: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R12: disabled translation always misses
  a_r12_disabled_miss: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !strobes.lookupEn) |=> (respValid && !respHit));

  // R5: an unqualified full flush empties the array
  a_r5_flush_all: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flushEn && strobes.flushMode == VA_ALL && !strobes.asidMatchEn &&
     !strobes.fillWe) |=> (validQ == '0));

  // R10: the reserved mode leaves the array untouched
  a_r10_reserved_mode: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flushEn && strobes.flushMode == VA_RSVD && !strobes.fillWe)
      |=> (validQ == $past(validQ)));

  // R11: a lookup beside a full flush sees the emptied array
  a_r11_flush_lookup: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && strobes.flushEn && strobes.flushMode == VA_ALL &&
     !strobes.asidMatchEn) |=> !respHit);
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_asid_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              translateEn,
  input  logic [5:0]        activeLines,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [ASID_W-1:0] lookupAsid,
  output logic              respValid,
  output logic              respHit,
  output logic [PFN_W-1:0]  respPfn,
  output logic [PERM_W-1:0] respPerm,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              flushValid,
  input  logic [CMD_W-1:0]  flushCmd
);
  tlbStrobeT            strobes;
  logic [NUM_LINES-1:0] validVec;
  logic [NUM_LINES-1:0] lineActive;

  tlb_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .translateEn(translateEn),
    .activeLines(activeLines),
    .fillValid  (fillValid),
    .flushValid (flushValid),
    .flushCmd   (flushCmd),
    .validVec   (validVec),
    .lineActive (lineActive),
    .strobes    (strobes)
  );

  tlb_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .lineActive (lineActive),
    .lookupValid(lookupValid),
    .lookupVpn  (lookupVpn),
    .lookupAsid (lookupAsid),
    .fillVpn    (fillVpn),
    .fillAsid   (fillAsid),
    .fillPfn    (fillPfn),
    .fillPerm   (fillPerm),
    .validVec   (validVec),
    .respValid  (respValid),
    .respHit    (respHit),
    .respPfn    (respPfn),
    .respPerm   (respPerm)
  );
endmodule

// File: tb/tb_tlb_asid_cache.sv
module tb_tlb_asid_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        translateEn;
  logic [5:0]  activeLines;
  logic        lookupValid;
  logic [19:0] lookupVpn;
  logic [6:0]  lookupAsid;
  logic        respValid;
  logic        respHit;
  logic [19:0] respPfn;
  logic [2:0]  respPerm;
  logic        fillValid;
  logic [19:0] fillVpn;
  logic [6:0]  fillAsid;
  logic [19:0] fillPfn;
  logic [2:0]  fillPerm;
  logic        flushValid;
  logic [31:0] flushCmd;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    logic [2:0]  perm;
    string       tag;
  } expT;
  expT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_asid_cache dut (
    .clk(clk), .rstN(rstN), .translateEn(translateEn), .activeLines(activeLines),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupAsid(lookupAsid),
    .respValid(respValid), .respHit(respHit), .respPfn(respPfn), .respPerm(respPerm),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid),
    .fillPfn(fillPfn), .fillPerm(fillPerm),
    .flushValid(flushValid), .flushCmd(flushCmd)
  );

  // monitor: compares each answer with the oldest expectation
  always @(negedge clk) begin
    if (rstN && respValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected answer: hit=%0b expected no answer", respHit);
      end else begin
        expT e;
        e = expQ.pop_front();
        if (respHit !== e.hit ||
            (e.hit && (respPfn !== e.pfn || respPerm !== e.perm))) begin
          fails++;
          $display("FAIL %s: hit=%0b pfn=%h perm=%0d expected hit=%0b pfn=%h perm=%0d",
                   e.tag, respHit, respPfn, respPerm, e.hit, e.pfn, e.perm);
        end
      end
    end
  end

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run still going, expected completion");
    finishUp();
  end

  function automatic logic [19:0] eVpn(int i); return 20'h10000 + 20'(i); endfunction
  function automatic logic [6:0]  eAsid(int i); return 7'(i + 1); endfunction
  function automatic logic [19:0] ePfn(int i); return 20'h20000 + 20'(i); endfunction
  function automatic logic [2:0]  ePerm(int i); return 3'(i); endfunction

  task automatic idle();
    lookupValid = 0; fillValid = 0; flushValid = 0;
  endtask

  task automatic doFill(input logic [19:0] v, input logic [6:0] a,
                        input logic [19:0] p, input logic [2:0] pm);
    fillValid = 1; fillVpn = v; fillAsid = a; fillPfn = p; fillPerm = pm;
    @(negedge clk);
    idle();
  endtask

  task automatic doFlush(input logic [31:0] cmd);
    flushValid = 1; flushCmd = cmd;
    @(negedge clk);
    idle();
  endtask

  task automatic doLook(input logic [19:0] v, input logic [6:0] a, input logic hit,
                        input logic [19:0] p, input logic [2:0] pm, input string tag);
    expT e;
    e.hit = hit; e.pfn = p; e.perm = pm; e.tag = tag;
    expQ.push_back(e);
    lookupValid = 1; lookupVpn = v; lookupAsid = a;
    @(negedge clk);
    idle();
  endtask

  task automatic lookE(int i, logic hit, string tag);
    doLook(eVpn(i), eAsid(i), hit, ePfn(i), ePerm(i), tag);
  endtask

  initial begin
    rstN = 0; translateEn = 1; activeLines = 6'd32;
    lookupVpn = '0; lookupAsid = '0; fillVpn = '0; fillAsid = '0;
    fillPfn = '0; fillPerm = '0; flushCmd = '0;
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (respValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: respValid=%0b expected 0", respValid);
    end
    rstN = 1;
    @(negedge clk);

    // R1: basic hit and mismatch cases
    doLook(20'h12345, 7'd1, 0, '0, '0, "R1 empty miss");
    doFill(20'h12345, 7'd1, 20'hABCDE, 3'd5);
    doLook(20'h12345, 7'd1, 1, 20'hABCDE, 3'd5, "R1 hit");
    doLook(20'h12345, 7'd2, 0, '0, '0, "R1 asid mismatch");
    doLook(20'h12346, 7'd1, 0, '0, '0, "R1 vpn mismatch");

    // R5: full flush
    doFlush(32'h0000_0000);
    doLook(20'h12345, 7'd1, 0, '0, '0, "R5 flush all");

    // R2 R3 replacement over four active lines
    activeLines = 6'd4;
    for (int i = 0; i < 4; i++) doFill(eVpn(i), eAsid(i), ePfn(i), ePerm(i));
    for (int i = 0; i < 4; i++) lookE(i, 1, "R2 fill to free lines");
    doFill(eVpn(4), eAsid(4), ePfn(4), ePerm(4));
    lookE(0, 0, "R3 first victim line0");
    lookE(1, 1, "R3 line1 kept");
    lookE(4, 1, "R3 new entry");
    doFill(eVpn(5), eAsid(5), ePfn(5), ePerm(5));
    lookE(1, 0, "R3 second victim line1");
    // R6: identifier flush frees line 3
    doFlush(32'h8000_0000 | (32'(eAsid(3)) << 24));
    lookE(3, 0, "R6 asid flush removed");
    lookE(2, 1, "R6 other asid kept");
    doFill(eVpn(6), eAsid(6), ePfn(6), ePerm(6));
    lookE(2, 1, "R2 free line preferred over victim");
    lookE(6, 1, "R2 filled free line");
    doFill(eVpn(7), eAsid(7), ePfn(7), ePerm(7));
    lookE(2, 0, "R3 victim line2");
    doFill(eVpn(8), eAsid(8), ePfn(8), ePerm(8));
    lookE(6, 0, "R3 victim line3");
    doFill(eVpn(9), eAsid(9), ePfn(9), ePerm(9));
    lookE(4, 0, "R3 wrap to line0");
    lookE(5, 1, "R3 line1 kept after wrap");
    lookE(8, 1, "R3 line3 kept after wrap");

    // R4: shrink and regrow the active window
    activeLines = 6'd2;
    lookE(7, 0, "R4 inactive line misses");
    lookE(9, 1, "R4 active line hits");
    activeLines = 6'd4;
    lookE(7, 1, "R4 line visible again");

    doFlush(32'h0000_0000);
    activeLines = 6'd32;

    // R7: section flush
    doFill(20'h00400, 7'd1, 20'h00001, 3'd1);
    doFill(20'h007FF, 7'd1, 20'h00002, 3'd2);
    doFill(20'h00800, 7'd1, 20'h00003, 3'd3);
    doFlush(32'h0000_0402);
    doLook(20'h00400, 7'd1, 0, '0, '0, "R7 section start removed");
    doLook(20'h007FF, 7'd1, 0, '0, '0, "R7 section end removed");
    doLook(20'h00800, 7'd1, 1, 20'h00003, 3'd3, "R7 next section kept");

    // R8: group flush
    doFill(20'h01004, 7'd1, 20'h00011, 3'd1);
    doFill(20'h01007, 7'd1, 20'h00012, 3'd2);
    doFill(20'h01008, 7'd1, 20'h00013, 3'd3);
    doFlush(32'h0000_1007);
    doLook(20'h01004, 7'd1, 0, '0, '0, "R8 group start removed");
    doLook(20'h01007, 7'd1, 0, '0, '0, "R8 group end removed");
    doLook(20'h01008, 7'd1, 1, 20'h00013, 3'd3, "R8 next group kept");

    // R9: identifier and group together
    doFill(20'h02000, 7'd5, 20'h00021, 3'd1);
    doFill(20'h02000, 7'd6, 20'h00022, 3'd2);
    doFill(20'h02001, 7'd5, 20'h00023, 3'd3);
    doFlush(32'h8500_2003);
    doLook(20'h02000, 7'd5, 0, '0, '0, "R9 both match removed");
    doLook(20'h02001, 7'd5, 0, '0, '0, "R9 both match removed 2");
    doLook(20'h02000, 7'd6, 1, 20'h00022, 3'd2, "R9 asid differs kept");
    doLook(20'h01008, 7'd1, 1, 20'h00013, 3'd3, "R9 other group kept");

    // R10: reserved mode
    doFlush(32'h0000_0001);
    doLook(20'h02000, 7'd6, 1, 20'h00022, 3'd2, "R10 reserved mode no effect");
    doLook(20'h00800, 7'd1, 1, 20'h00003, 3'd3, "R10 reserved mode no effect 2");

    // R11: lookup beside a flush
    flushValid = 1; flushCmd = 32'h0000_0000;
    doLook(20'h00800, 7'd1, 0, '0, '0, "R11 lookup sees flushed state");

    // R13: fill beside a flush
    flushValid = 1; flushCmd = 32'h0000_0000;
    doFill(20'h04000, 7'd9, 20'h00044, 3'd4);
    doLook(20'h04000, 7'd9, 1, 20'h00044, 3'd4, "R13 fill survives flush");

    // R12: disabled translation
    translateEn = 0;
    doLook(20'h04000, 7'd9, 0, '0, '0, "R12 disabled miss");
    doFill(20'h05000, 7'd9, 20'h00055, 3'd5);
    translateEn = 1;
    doLook(20'h04000, 7'd9, 1, 20'h00044, 3'd4, "R12 entry kept while disabled");
    doLook(20'h05000, 7'd9, 0, '0, '0, "R12 fill ignored while disabled");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1 missing answers: %0d pending expected 0", expQ.size());
    end
    finishUp();
  end
endmodule